// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked list of 8-byte region descriptors that sit back to back in memory, starting from a pointer handed over with a start pulse. It reads each descriptor through a simple fetch port. It checks the segment the descriptor names, then asks a data mover to carry out that segment. It waits for the mover's done signal and adds the segment length to a running byte count.

The walk ends at a descriptor whose end marker is set. The block then compares the byte count against the expected total that came with the start pulse. That expected total includes any command-packet segment. The block raises a one-cycle done pulse together with a response flag byte.

The walk can also end early. A malformed segment ends it, and so does a chain that runs past its entry limit. In both cases only the summary error flag is reported.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor read on `fetch_data` is decoded little-endian. Bits 31:0 are the segment address, bits 47:32 are the byte length, bits 55:48 are ignored and bits 63:56 are the flags. The first descriptor is fetched at `start_ptr`, and each following one at the previous fetch address plus 8. Each segment is issued on `xfer_addr`/`xfer_len`.
- R2: Descriptor flag bits drive the transfer qualifiers. Bit 2 drives `xfer_cdb` (command-packet segment), bit 4 drives `xfer_dma` (DMA method) and bit 5 drives `xfer_to_dev` (direction toward the device).
- R3: Flag bit 7 marks the last descriptor. No further fetch is made after its transfer completes, and `done` pulses for exactly one cycle with response bit 0 (complete) set.
- R4: If the byte total is below the expected length at the end, the response is 0xA1: bit 5 (short), bit 7 (error) and bit 0.
- R5: If the byte total is above the expected length at the end, the response is 0xC1: bit 6 (excess), bit 7 and bit 0.
- R6: An excess is not reported when flag bit 1 (drain) is set on the last descriptor, and the response is then 0x01. Drain set on an earlier descriptor has no such effect.
- R7: A segment length of 0 (the code for 65536) or above 65024 is rejected. No transfer is issued for it and the walk ends with response 0x80. A length of exactly 65024 is accepted.
- R8: A segment whose first and last byte addresses differ in bits 31:24 (it crosses a 16 MiB boundary) is rejected in the same way, with response 0x80.
- R9: If 129 descriptors have been transferred and none carried the end marker, the walk stops with response 0x80. If the 129th descriptor is the last one, the walk completes normally.
- R10: `busy` is high from the cycle after an accepted start up to and including the `done` cycle. A start pulse while `busy` is high, including during the `done` cycle, is ignored.
- R11: After reset, `busy`, `done`, `fetch_req` and `xfer_req` are low.
- R12: When the byte total equals the expected length, command-packet segments included, the response is exactly 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| start_ptr | input | 32 | Address of the first descriptor |
| start_len | input | 32 | Expected total byte count |
| busy | output | 1 | Walk in progress |
| fetch_req | output | 1 | Descriptor read request |
| fetch_addr | output | 32 | Descriptor read address |
| fetch_ack | input | 1 | Descriptor data valid |
| fetch_data | input | 64 | Descriptor contents |
| xfer_req | output | 1 | Segment transfer request |
| xfer_addr | output | 32 | Segment address |
| xfer_len | output | 16 | Segment byte length |
| xfer_cdb | output | 1 | Segment is a command packet |
| xfer_dma | output | 1 | Segment uses the DMA method |
| xfer_to_dev | output | 1 | Segment moves toward the device |
| xfer_done | input | 1 | Data mover finished the segment |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Response flags, valid while done is high |

## Verification
Two decisions can fall on the same final descriptor. The excess-length test can fire, and the drain flag can suppress it. The bench builds chains that overshoot the expected total with drain set on the last entry and with drain set only on an earlier entry, and expects 0x01 and 0xC1 respectively. The other collision is between a new start pulse and the completion cycle. The bench raises `start` in the very cycle it sees `done` and then requires `busy` and `fetch_req` to stay low, so that no second walk begins.

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int MAX_SEG     = 65024,
  parameter int MAX_ENTRIES = 129
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic [31:0]   start_len,
  output logic          busy,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [63:0]   fetch_data,
  output logic          xfer_req,
  output logic [AW-1:0] xfer_addr,
  output logic [LW-1:0] xfer_len,
  output logic          xfer_cdb,
  output logic          xfer_dma,
  output logic          xfer_to_dev,
  input  logic          xfer_done,
  output logic          done,
  output logic [7:0]    resp
);
  localparam int CW = $clog2(MAX_ENTRIES + 1);
  localparam logic [LW:0] SEG_LIM = (LW+1)'(MAX_SEG);
  localparam logic [CW-1:0] CNT_LIM = CW'(MAX_ENTRIES);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_XFER, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] ptr_q, seg_addr;
  logic [LW-1:0] seg_len;
  logic [7:0]    seg_flg, resp_q;
  logic [31:0]   exp_q, total_q;
  logic [CW-1:0] cnt_q;

  wire [AW:0]  seg_end  = {1'b0, seg_addr} + (AW+1)'(seg_len) - 1'b1;
  wire         len_bad  = (seg_len == '0) || ({1'b0, seg_len} > SEG_LIM);
  wire         crosses  = seg_end[AW:24] != {1'b0, seg_addr[AW-1:24]};
  wire [31:0]  total_n  = total_q + 32'(seg_len);
  wire         is_last  = seg_flg[7];
  wire         short_n  = total_n < exp_q;
  wire         excess_n = (total_n > exp_q) && !seg_flg[1];

  assign busy        = st != S_IDLE;
  assign fetch_req   = st == S_FETCH;
  assign fetch_addr  = ptr_q;
  assign xfer_req    = st == S_XFER;
  assign xfer_addr   = seg_addr;
  assign xfer_len    = seg_len;
  assign xfer_cdb    = seg_flg[2];
  assign xfer_dma    = seg_flg[4];
  assign xfer_to_dev = seg_flg[5];
  assign done        = st == S_DONE;
  assign resp        = resp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr_q    <= '0;
      seg_addr <= '0;
      seg_len  <= '0;
      seg_flg  <= '0;
      exp_q    <= '0;
      total_q  <= '0;
      cnt_q    <= '0;
      resp_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ptr_q   <= start_ptr;
          exp_q   <= start_len;
          total_q <= '0;
          cnt_q   <= '0;
          resp_q  <= '0;
          st      <= S_FETCH;
        end
        S_FETCH: if (fetch_ack) begin
          seg_addr <= fetch_data[31:0];
          seg_len  <= fetch_data[47:32];
          seg_flg  <= fetch_data[63:56];
          st       <= S_CHECK;
        end
        S_CHECK: begin
          if (len_bad || crosses) begin
            resp_q <= 8'h80;
            st     <= S_DONE;
          end else begin
            st <= S_XFER;
          end
        end
        S_XFER: if (xfer_done) begin
          total_q <= total_n;
          cnt_q   <= cnt_q + 1'b1;
          if (is_last) begin
            resp_q <= {short_n | excess_n, excess_n, short_n, 4'b0, 1'b1};
            st     <= S_DONE;
          end else if (cnt_q + 1'b1 == CNT_LIM) begin
            resp_q <= 8'h80;
            st     <= S_DONE;
          end else begin
            ptr_q <= ptr_q + AW'(8);
            st    <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R4
  short_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp[5]) |-> (resp[7] && resp[0] && !resp[6]));
  // R5
  excess_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp[6]) |-> (resp[7] && resp[0]));
  // R7
  seg_len_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0 && {1'b0, xfer_len} <= SEG_LIM));
  // R1
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));
  // R1
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [31:0] start_ptr = 0, start_len = 0;
  logic        busy, fetch_req, xfer_req, done;
  logic [31:0] fetch_addr, xfer_addr;
  logic        fetch_ack = 0;
  logic [63:0] fetch_data = 0;
  logic [15:0] xfer_len;
  logic        xfer_cdb, xfer_dma, xfer_to_dev;
  logic        xfer_done = 0;
  logic [7:0]  resp;

  int checks = 0, errors = 0, cycles = 0, xcnt = 0;
  logic [63:0] mem [logic [31:0]];
  logic [50:0] exp_xq [$];
  logic [7:0]  exp_rq [$];

  always #5 clk = ~clk;

  sg_chain_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .start_len(start_len), .busy(busy), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_cdb(xfer_cdb), .xfer_dma(xfer_dma), .xfer_to_dev(xfer_to_dev),
    .xfer_done(xfer_done), .done(done), .resp(resp));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] at, input logic [31:0] a, input logic [15:0] l, input logic [7:0] f);
    mem[at] = {f, 8'h00, l, a};
  endtask

  task automatic expx(input logic [31:0] a, input logic [15:0] l, input logic [7:0] f);
    exp_xq.push_back({a, l, f[2], f[4], f[5]});
  endtask

  // descriptor fetch responder
  initial forever begin
    @(negedge clk);
    fetch_ack = fetch_req;
    fetch_data = mem.exists(fetch_addr) ? mem[fetch_addr] : 64'h0;
  end

  // data mover model and transfer/response monitor
  initial forever begin
    @(negedge clk);
    cycles++;
    if (xfer_req) begin
      if (xcnt == 2) begin
        xfer_done = 1; xcnt = 0;
        if (exp_xq.size() == 0) chk(0, "R1 unexpected transfer", {13'b0, xfer_addr, xfer_len, xfer_cdb, xfer_dma, xfer_to_dev}, 0);
        else begin
          logic [50:0] e;
          e = exp_xq.pop_front();
          chk({xfer_addr, xfer_len} == e[50:3], "R1 segment addr/len", {xfer_addr, xfer_len}, e[50:3]);
          chk({xfer_cdb, xfer_dma, xfer_to_dev} == e[2:0], "R2 segment qualifiers", {xfer_cdb, xfer_dma, xfer_to_dev}, e[2:0]);
        end
      end else begin xfer_done = 0; xcnt++; end
    end else begin xfer_done = 0; xcnt = 0; end
    if (done) begin
      if (exp_rq.size() == 0) chk(0, "R3 unexpected done", resp, 0);
      else begin
        logic [7:0] er;
        er = exp_rq.pop_front();
        chk(resp == er, "R3/R4/R5/R6/R7/R8/R9/R12 response", resp, er);
      end
    end
  end

  initial begin
    wait (cycles >= 150000);
    chk(0, "watchdog", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run(input logic [31:0] p, input logic [31:0] l, input logic [7:0] r, input string tag);
    exp_rq.push_back(r);
    @(negedge clk);
    start = 1; start_ptr = p; start_len = l;
    @(negedge clk);
    start = 0;
    wait_done();
    @(negedge clk);
    chk(exp_xq.size() == 0, {tag, " all transfers issued"}, exp_xq.size(), 0);
    chk(!busy, {tag, " idle after done"}, busy, 0);
    exp_xq.delete();
    mem.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fetch_req && !xfer_req, "R11 reset outputs", {busy, done, fetch_req, xfer_req}, 0);
    rst_n = 1;

    // R12 single entry exact
    put(32'h100, 32'h1000_0000, 16'd512, 8'h90); expx(32'h1000_0000, 16'd512, 8'h90);
    run(32'h100, 32'd512, 8'h01, "R12");

    // R1 R2 R12 three entries with command packet first
    put(32'h200, 32'h3000_0000, 16'd12, 8'h24);   expx(32'h3000_0000, 16'd12, 8'h24);
    put(32'h208, 32'h3100_0000, 16'd4096, 8'h30); expx(32'h3100_0000, 16'd4096, 8'h30);
    put(32'h210, 32'h3200_0000, 16'd2048, 8'h90); expx(32'h3200_0000, 16'd2048, 8'h90);
    run(32'h200, 32'd6156, 8'h01, "R1");

    // R4 short
    put(32'h300, 32'h100, 16'd1000, 8'h80); expx(32'h100, 16'd1000, 8'h80);
    run(32'h300, 32'd2000, 8'hA1, "R4");
    // R5 excess
    put(32'h300, 32'h100, 16'd3000, 8'h80); expx(32'h100, 16'd3000, 8'h80);
    run(32'h300, 32'd2000, 8'hC1, "R5");
    // R6 drain on last suppresses excess
    put(32'h300, 32'h100, 16'd3000, 8'h82); expx(32'h100, 16'd3000, 8'h82);
    run(32'h300, 32'd2000, 8'h01, "R6");
    // R6 drain on earlier entry only
    put(32'h300, 32'h100, 16'd1500, 8'h02); expx(32'h100, 16'd1500, 8'h02);
    put(32'h308, 32'h900, 16'd1500, 8'h80); expx(32'h900, 16'd1500, 8'h80);
    run(32'h300, 32'd2000, 8'hC1, "R6");

    // R7 length zero, then partial chain with bad second length
    put(32'h400, 32'h100, 16'd0, 8'h80);
    run(32'h400, 32'd0, 8'h80, "R7");
    put(32'h400, 32'h100, 16'd100, 8'h00); expx(32'h100, 16'd100, 8'h00);
    put(32'h408, 32'h500, 16'd65025, 8'h80);
    run(32'h400, 32'd65125, 8'h80, "R7");
    put(32'h400, 32'h100, 16'd65024, 8'h80); expx(32'h100, 16'd65024, 8'h80);
    run(32'h400, 32'd65024, 8'h01, "R7");

    // R8 boundary crossing vs ending exactly at boundary
    put(32'h500, 32'h00FF_FF00, 16'd512, 8'h80);
    run(32'h500, 32'd512, 8'h80, "R8");
    put(32'h500, 32'h00FF_FE00, 16'd512, 8'h80); expx(32'h00FF_FE00, 16'd512, 8'h80);
    run(32'h500, 32'd512, 8'h01, "R8");

    // R9 entry limit
    for (int i = 0; i < 129; i++) begin
      put(32'h8000 + 8*i, 32'h2000_0000 + 16*i, 16'd16, 8'h00);
      expx(32'h2000_0000 + 16*i, 16'd16, 8'h00);
    end
    run(32'h8000, 32'd2064, 8'h80, "R9");
    for (int i = 0; i < 129; i++) begin
      put(32'h8000 + 8*i, 32'h2000_0000 + 16*i, 16'd16, (i == 128) ? 8'h80 : 8'h00);
      expx(32'h2000_0000 + 16*i, 16'd16, (i == 128) ? 8'h80 : 8'h00);
    end
    run(32'h8000, 32'd2064, 8'h01, "R9");

    // R10 start while busy, and start in the done cycle
    put(32'h600, 32'h100, 16'd64, 8'h00); expx(32'h100, 16'd64, 8'h00);
    put(32'h608, 32'h200, 16'd64, 8'h80); expx(32'h200, 16'd64, 8'h80);
    put(32'h700, 32'h900, 16'd8, 8'h80);
    exp_rq.push_back(8'h01);
    @(negedge clk); start = 1; start_ptr = 32'h600; start_len = 32'd128;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    start = 1; start_ptr = 32'h700; start_len = 32'd8;
    @(negedge clk); start = 0;
    chk(busy, "R10 busy mid walk", busy, 1);
    wait_done();
    chk(busy, "R10 busy in done cycle", busy, 1);
    start = 1; start_ptr = 32'h700; start_len = 32'd8;
    @(negedge clk); start = 0;
    chk(!busy && !fetch_req, "R10 start in done cycle ignored", {busy, fetch_req}, 0);
    repeat (2) @(negedge clk);
    chk(!busy && !fetch_req, "R10 stays idle", {busy, fetch_req}, 0);
    chk(exp_xq.size() == 0, "R10 transfers", exp_xq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule